// File: doc/BRIEF.md
# Multi-Format 8x8 Multiplier

This block multiplies two 8-bit operands and returns a 16-bit product together with a carry flag and a zero flag. A 3-bit format code selects how each operand is read (as unsigned or as two's complement) and whether the result is an integer or a fractional product.

In the fractional formats both operands are taken as 1.7 fixed-point values. The integer product is then shifted left by one bit, so the result is a 1.15 value.

The caller raises `start_i` for one cycle with the operands and the format code. The block captures them, and one clock edge later it presents the result and pulses `done_o`. A second start that arrives while an operation is still in flight is dropped. The result outputs hold their last value until the next operation completes.

Top module: `fmt_mul8`

## Requirements
- R1: `fmt_i` encoding: 0 = unsigned x unsigned, 1 = signed x signed, 2 = signed `a_i` x unsigned `b_i`, 3 = fractional unsigned x unsigned, 4 = fractional signed x signed, 5 = fractional signed `a_i` x unsigned `b_i`; codes 6 and 7 behave exactly as code 0.
- R2: In format 0, `result_o` is the unsigned 16-bit product of `a_i` and `b_i`.
- R3: In format 1, `result_o` is the low 16 bits of the two's-complement product of both operands.
- R4: In format 2, `a_i` is read as two's complement and `b_i` as unsigned, and `result_o` is the low 16 bits of their product.
- R5: In formats 3, 4 and 5, `result_o` is the matching integer product (signedness as in formats 0, 1 and 2) shifted left by one bit, with bit 0 equal to zero. For example, 0x80 x 0x80 in format 4 gives 0x8000.
- R6: `carry_o` equals bit 15 of the integer product before any fractional shift.
- R7: `zero_o` is 1 exactly when the final 16-bit `result_o` is zero.
- R8: When `start_i` is sampled high at rising edge k and accepted, `result_o`, `carry_o` and `zero_o` update and `done_o` goes high at edge k+1. `done_o` stays high for exactly one cycle.
- R9: A `start_i` sampled at the edge that follows an accepted start is ignored. It produces no `done_o` and no change of the outputs. A start at the edge after that is accepted.
- R10: Between two `done_o` pulses, `result_o`, `carry_o` and `zero_o` hold their values.
- R11: While `rst_ni` is low, `result_o`, `carry_o`, `zero_o` and `done_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch an operation with the current operands |
| a_i | input | 8 | Multiplicand |
| b_i | input | 8 | Multiplier |
| fmt_i | input | 3 | Format code (see R1) |
| result_o | output | 16 | Product |
| carry_o | output | 1 | Bit 15 of the unshifted product |
| zero_o | output | 1 | Result is zero |
| done_o | output | 1 | One-cycle pulse: result valid |

## Verification
Every result is due at the edge that follows the one sampling `start_i`. The bench therefore drives inputs at a falling edge and drops `start_i` at the next falling edge. It then checks the result, the flags and `done_o` at the falling edge after that, so back-to-back operations run at one per two cycles.

For the ignored-start case, the bench holds `start_i` high across the busy edge. It checks that the first operands' result appears, and that one cycle later `done_o` is low and the result has not moved.

// File: rtl/fmt_mul8_pkg.sv
package fmt_mul8_pkg;

  typedef enum logic [2:0] {
    FMT_UU  = 3'd0,
    FMT_SS  = 3'd1,
    FMT_SU  = 3'd2,
    FMT_FUU = 3'd3,
    FMT_FSS = 3'd4,
    FMT_FSU = 3'd5
  } fmt_e;

  typedef struct packed {
    logic a_sgn;
    logic b_sgn;
    logic frac;
  } mode_t;

  function automatic mode_t decode_fmt(input logic [2:0] code);
    mode_t m;
    m = '0;
    case (code)
      FMT_SS:  begin m.a_sgn = 1'b1; m.b_sgn = 1'b1; end
      FMT_SU:  begin m.a_sgn = 1'b1; end
      FMT_FUU: begin m.frac = 1'b1; end
      FMT_FSS: begin m.a_sgn = 1'b1; m.b_sgn = 1'b1; m.frac = 1'b1; end
      FMT_FSU: begin m.a_sgn = 1'b1; m.frac = 1'b1; end
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/fmt_mul8_capture.sv
module fmt_mul8_capture
  import fmt_mul8_pkg::*;
#(
  parameter int W  = 8,
  localparam int XW = W + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [2:0]    fmt_i,
  output logic          pend_o,
  output logic [XW-1:0] a_x_o,
  output logic [XW-1:0] b_x_o,
  output logic          frac_o
);

  mode_t        mode;
  logic         pend_q, frac_q;
  logic [XW-1:0] a_q, b_q;

  assign mode = decode_fmt(fmt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      frac_q <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
    end else if (start_i && !pend_q) begin
      pend_q <= 1'b1;
      frac_q <= mode.frac;
      // extend by one bit: sign bit for signed operands, zero otherwise
      a_q    <= {mode.a_sgn & a_i[W-1], a_i};
      b_q    <= {mode.b_sgn & b_i[W-1], b_i};
    end else begin
      pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign a_x_o  = a_q;
  assign b_x_o  = b_q;
  assign frac_o = frac_q;

endmodule

// File: rtl/fmt_mul8_array.sv
module fmt_mul8_array #(
  parameter int W  = 8,
  localparam int XW = W + 1,
  localparam int PW = 2 * W
) (
  input  logic [XW-1:0] a_x_i,
  input  logic [XW-1:0] b_x_i,
  output logic [PW-1:0] prod_o
);

  logic [PW-1:0] a_ext;
  logic [PW-1:0] pp  [XW];
  logic [PW-1:0] acc [XW+1];

  assign a_ext  = {{(PW-XW){a_x_i[XW-1]}}, a_x_i};
  assign acc[0] = '0;

  for (genvar i = 0; i < XW; i++) begin : g_row
    if (i == XW - 1) begin : g_sign
      // top bit of the extended multiplier carries negative weight
      assign pp[i] = b_x_i[i] ? (~(a_ext << i) + 1'b1) : '0;
    end else begin : g_mag
      assign pp[i] = b_x_i[i] ? (a_ext << i) : '0;
    end
    assign acc[i+1] = acc[i] + pp[i];
  end

  assign prod_o = acc[XW];

endmodule

// File: rtl/fmt_mul8_post.sv
module fmt_mul8_post #(
  parameter int W  = 8,
  localparam int PW = 2 * W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          frac_i,
  input  logic [PW-1:0] prod_i,
  output logic [PW-1:0] result_o,
  output logic          carry_o,
  output logic          zero_o,
  output logic          done_o
);

  logic [PW-1:0] shaped;
  logic [PW-1:0] res_q;
  logic          carry_q, zero_q, done_q;

  always_comb begin
    shaped = frac_i ? {prod_i[PW-2:0], 1'b0} : prod_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= valid_i;
      if (valid_i) begin
        res_q   <= shaped;
        carry_q <= prod_i[PW-1];
        zero_q  <= (shaped == '0);
      end
    end
  end

  assign result_o = res_q;
  assign carry_o  = carry_q;
  assign zero_o   = zero_q;
  assign done_o   = done_q;

endmodule

// File: rtl/fmt_mul8.sv
module fmt_mul8 #(
  parameter int W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [2:0]     fmt_i,
  output logic [2*W-1:0] result_o,
  output logic           carry_o,
  output logic           zero_o,
  output logic           done_o
);

  localparam int XW = W + 1;
  localparam int PW = 2 * W;

  logic          pend;
  logic          frac;
  logic [XW-1:0] a_x, b_x;
  logic [PW-1:0] prod;

  fmt_mul8_capture #(.W(W)) i_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .fmt_i   (fmt_i),
    .pend_o  (pend),
    .a_x_o   (a_x),
    .b_x_o   (b_x),
    .frac_o  (frac)
  );

  fmt_mul8_array #(.W(W)) i_array (
    .a_x_i  (a_x),
    .b_x_i  (b_x),
    .prod_o (prod)
  );

  fmt_mul8_post #(.W(W)) i_post (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (pend),
    .frac_i   (frac),
    .prod_i   (prod),
    .result_o (result_o),
    .carry_o  (carry_o),
    .zero_o   (zero_o),
    .done_o   (done_o)
  );

endmodule

// File: rtl/fmt_mul8_chk.sv
module fmt_mul8_chk #(
  parameter int W = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic [W-1:0]   a_i,
  input logic [W-1:0]   b_i,
  input logic [2:0]     fmt_i,
  input logic [2*W-1:0] result_o,
  input logic           carry_o,
  input logic           zero_o,
  input logic           done_o
);

  logic acc_q, frac_q;
  logic unused_ops;

  assign unused_ops = ^{a_i, b_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= 1'b0;
      frac_q <= 1'b0;
    end else begin
      acc_q <= start_i && !acc_q;
      if (start_i && !acc_q) frac_q <= (fmt_i >= 3'd3) && (fmt_i <= 3'd5);
    end
  end

  // R8
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q |=> done_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  no_spurious_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(acc_q));

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(result_o) && $stable(carry_o) && $stable(zero_o)));

  // R7
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (zero_o == (result_o == '0)));

  // R5
  frac_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && frac_q) |-> !result_o[0]);

  // R11
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (!done_o && !carry_o && !zero_o && result_o == '0);
    end
  end

endmodule

bind fmt_mul8 fmt_mul8_chk #(.W(W)) i_chk (.*);

// File: tb/test_fmt_mul8.sv
`timescale 1ns/1ps
module test_fmt_mul8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  a = '0, b = '0;
  logic [2:0]  fmt = '0;
  logic [15:0] result;
  logic        carry, zero, done;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  fmt_mul8 #(.W(8)) i_fmt_mul8 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .a_i(a), .b_i(b), .fmt_i(fmt),
    .result_o(result), .carry_o(carry), .zero_o(zero), .done_o(done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (a=%0h b=%0h fmt=%0d)",
               req, act, exp, a, b, fmt);
    end
  endtask

  // expected raw (unshifted) product, low 16 bits
  function automatic int raw_prod(input int x, input int y, input int f);
    int sx, sy, p;
    sx = x; sy = y;
    if ((f == 1 || f == 2 || f == 4 || f == 5) && x >= 128) sx = x - 256;
    if ((f == 1 || f == 4) && y >= 128) sy = y - 256;
    p = sx * sy;
    return p & 16'hFFFF;
  endfunction

  function automatic string fmt_req(input int f);
    case (f)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3, 4, 5: return "R5";
      default: return "R1";
    endcase
  endfunction

  // call at a falling edge; returns at a falling edge two cycles later
  task automatic op(input int x, input int y, input int f);
    int raw, res;
    start = 1'b1; a = x[7:0]; b = y[7:0]; fmt = f[2:0];
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    raw = raw_prod(x, y, f);
    res = (f >= 3 && f <= 5) ? ((raw << 1) & 16'hFFFF) : raw;
    check("R8 done", int'(done), 1);
    check(fmt_req(f), int'(result), res);
    check("R6 carry", int'(carry), (raw >> 15) & 1);
    check("R7 zero", int'(zero), (res == 0) ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int corner[12];
    int hold;
    corner = '{0, 1, 2, 3, 64, 127, 128, 129, 254, 255, 8'h55, 8'hAA};

    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 done", int'(done), 0);
    check("R11 result", int'(result), 0);
    check("R11 carry", int'(carry), 0);
    check("R11 zero", int'(zero), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 corner: -1.0 * -1.0 wraps
    op(8'h80, 8'h80, 4);
    check("R5 wrap", int'(result), 16'h8000);

    // R1 codes 6,7 behave as unsigned integer
    op(8'hFF, 8'hFF, 6);
    check("R1 code6", int'(result), 16'hFE01);
    op(8'h80, 8'hFF, 7);
    check("R1 code7", int'(result), 16'h7F80);

    // near-exhaustive: all a against corner b, every format code
    for (int f = 0; f < 8; f++)
      for (int x = 0; x < 256; x++)
        for (int k = 0; k < 12; k++)
          op(x, corner[k], f);

    // strided cross sweep on the six named formats
    for (int f = 0; f < 6; f++)
      for (int x = 0; x < 256; x += 7)
        for (int y = 0; y < 256; y += 7)
          op(x, y, f);

    // R9: start held over the busy edge is ignored
    start = 1'b1; a = 8'd3; b = 8'd5; fmt = 3'd0;
    @(negedge clk);
    a = 8'd200; b = 8'd200;
    @(negedge clk);
    start = 1'b0;
    check("R9 done", int'(done), 1);
    check("R9 result", int'(result), 15);
    @(negedge clk);
    check("R9 no second done", int'(done), 0);
    check("R10 hold", int'(result), 15);

    // R10: idle cycles keep outputs
    hold = int'(result);
    repeat (5) @(negedge clk);
    check("R10 idle done", int'(done), 0);
    check("R10 idle result", int'(result), hold);

    // accepted again after idle
    op(8'd200, 8'd200, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule